// File: doc/BRIEF.md
# Hold-and-Load Debug Loader Controller

This controller sits beside a soft CPU and keeps the CPU halted from reset until a host has finished loading a program. The host speaks to it over a UART link: a byte-level receiver hands it one byte per `rx_valid` strobe, and a byte-level transmitter takes response bytes from it through a valid/ready handshake. The controller also drives the select line of the mux that decides whether the UART transmitter carries the CPU's output or the controller's responses.

After reset the CPU is held, yet the transmit mux still points at the CPU. The first well-formed debug frame moves the mux over to the controller. While the CPU is held, frames write words into program memory, read words back, and set the address the CPU will begin executing from. A start frame is acknowledged. Once the transmitter has taken that acknowledge byte, the controller fires a one-cycle start pulse, releases the hold and hands the transmitter back to the CPU. Running is terminal until the next reset.

A frame is eleven bytes: 0xA5, a command byte, a 32-bit address sent low byte first, a 32-bit data word sent low byte first, and a checksum byte. The checksum is chosen so that the XOR of all eleven bytes is zero. Command codes are 0x01 write word, 0x02 set start address (taken from the address field), 0x03 start, and 0x04 read word.

Top module: `hold_load_dbg`

## Requirements
- R1: After reset, `cpu_hold` is 1, `cpu_start` is 0, `tx_sel_dbg` is 0 (CPU side), `tx_valid` is 0, and `cpu_start_addr` is 0x80000000.
- R2: Frames are parsed in the byte layout above, with the address and data fields little-endian. A frame whose checksum makes the XOR of all eleven bytes zero is acted on in the cycle after the edge that accepts its checksum byte.
- R3: A valid frame accepted while the CPU is held sets `tx_sel_dbg` to 1. `tx_valid` is never 1 while `tx_sel_dbg` is 0.
- R4: A write frame (0x01) accepted while held drives `mem_we` high for exactly one cycle, with `mem_addr` equal to the address field and `mem_wdata` equal to the data field.
- R5: A set-address frame (0x02) copies its address field into `cpu_start_addr`.
- R6: Write, set-address and start frames accepted while held are answered with exactly one byte, 0x5A. A response byte stays on `tx_byte`, with `tx_valid` high, until `tx_ready` is seen.
- R7: A read frame (0x04) accepted while held drives `mem_re` high for one cycle with `mem_addr` equal to the address field. `mem_rdata` is sampled two edges later, and its four bytes are then sent least significant first.
- R8: For a start frame (0x03), at the edge where the 0x5A acknowledge is taken, the controller raises `cpu_start` for one cycle, drops `cpu_hold` and returns `tx_sel_dbg` to 0. The CPU then stays released.
- R9: A byte other than 0xA5 while waiting for sync, a command byte outside 0x01 to 0x04, or a checksum mismatch causes no memory access, no response and no change of `tx_sel_dbg`. The parser then waits for the next 0xA5.
- R10: While the CPU runs, write, read and start frames are ignored: no memory access, no response, and the mux stays on the CPU side. A set-address frame still updates `cpu_start_addr`.
- R11: A valid frame that completes while a response is still outstanding (bytes unsent or a read in flight) is discarded with no effect.
- R12: After 65536 consecutive cycles without `rx_valid`, a partly received frame is abandoned and the parser waits for sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the byte on `tx_byte` |
| tx_valid | output | 1 | Controller has a response byte pending |
| tx_byte | output | 8 | Response byte |
| tx_sel_dbg | output | 1 | Transmit mux select: 1 = controller, 0 = CPU |
| mem_we | output | 1 | Program memory write strobe |
| mem_re | output | 1 | Program memory read strobe |
| mem_addr | output | 32 | Program memory address |
| mem_wdata | output | 32 | Program memory write data |
| mem_rdata | input | 32 | Program memory read data, valid the cycle after `mem_re` |
| cpu_hold | output | 1 | Keeps the CPU from fetching |
| cpu_start | output | 1 | One-cycle start pulse |
| cpu_start_addr | output | 32 | Address the CPU begins executing from |

## Verification
A corrupted parser state, such as a wrong byte index or a stale running checksum, shows up at the ports on the checksum edge of the next frame: a write that should happen is missing, or a response byte is missing or extra, one cycle later. A wrong response-buffer count or byte order appears directly on `tx_byte` and `tx_valid` within a few handshakes. A wrong hold or mux flag is visible on the very next cycle, because both drive ports directly. The bench's reference model is compared against every output on every clock, so each of these faults is reported in the cycle it first shows.

// File: rtl/hld_pkg.sv
package hld_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;
    localparam logic [7:0] ACK_BYTE  = 8'h5A;

    typedef enum logic [7:0] {
        CMD_WRITE = 8'h01,
        CMD_SETPC = 8'h02,
        CMD_GO    = 8'h03,
        CMD_READ  = 8'h04
    } cmd_e;

    typedef enum logic [2:0] {
        PS_SYNC,
        PS_CMD,
        PS_ADDR,
        PS_DATA,
        PS_SUM
    } pstate_e;
endpackage

// File: rtl/hld_frame_rx.sv
module hld_frame_rx
    import hld_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int GAP_CYCLES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              frm_ok,
    output logic [7:0]        frm_cmd,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [DATA_W-1:0] frm_data
);
    localparam int ABYTES = ADDR_W / 8;
    localparam int DBYTES = DATA_W / 8;
    localparam int MAXB   = (ABYTES > DBYTES) ? ABYTES : DBYTES;
    localparam int IW     = (MAXB > 1) ? $clog2(MAXB) : 1;
    localparam int GW     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

    typedef struct packed {
        pstate_e           st;
        logic [7:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [IW-1:0]     idx;
        logic [7:0]        sum;
        logic [GW-1:0]     gap;
    } prx_t;

    prx_t q, d;

    always_comb begin
        d      = q;
        frm_ok = 1'b0;
        if (rx_valid) begin
            d.gap = '0;
            unique case (q.st)
                PS_SYNC: begin
                    if (rx_byte == SYNC_BYTE) begin
                        d.st  = PS_CMD;
                        d.sum = rx_byte;
                    end
                end
                PS_CMD: begin
                    if (rx_byte inside {CMD_WRITE, CMD_SETPC, CMD_GO, CMD_READ}) begin
                        d.cmd = rx_byte;
                        d.sum = q.sum ^ rx_byte;
                        d.idx = '0;
                        d.st  = PS_ADDR;
                    end else begin
                        d.st = PS_SYNC;
                    end
                end
                PS_ADDR: begin
                    d.addr = {rx_byte, q.addr[ADDR_W-1:8]};
                    d.sum  = q.sum ^ rx_byte;
                    if (q.idx == IW'(ABYTES - 1)) begin
                        d.idx = '0;
                        d.st  = PS_DATA;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PS_DATA: begin
                    d.data = {rx_byte, q.data[DATA_W-1:8]};
                    d.sum  = q.sum ^ rx_byte;
                    if (q.idx == IW'(DBYTES - 1)) begin
                        d.idx = '0;
                        d.st  = PS_SUM;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                PS_SUM: begin
                    frm_ok = (rx_byte == q.sum);
                    d.st   = PS_SYNC;
                end
                default: d.st = PS_SYNC;
            endcase
        end else if (q.st != PS_SYNC) begin
            if (q.gap == GW'(GAP_CYCLES - 1)) begin
                d.st  = PS_SYNC;
                d.gap = '0;
            end else begin
                d.gap = q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frm_cmd  = q.cmd;
    assign frm_addr = q.addr;
    assign frm_data = q.data;

    // R12: the idle counter only runs inside a frame
    assert_gap_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_SYNC) |-> (q.gap == '0));

    // R9: a checksum verdict only comes from the last byte position
    assert_ok_on_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok |=> (q.st == PS_SYNC));
endmodule

// File: rtl/hld_resp_tx.sv
module hld_resp_tx
    import hld_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ack,
    input  logic              load_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              busy,
    output logic              last_done
);
    localparam int DBYTES = DATA_W / 8;
    localparam int CW     = $clog2(DBYTES + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sbuf;
        logic [CW-1:0]     left;
        logic [1:0]        rwait;
    } rsp_t;

    rsp_t q, d;

    always_comb begin
        d         = q;
        last_done = 1'b0;
        tx_valid  = (q.left != '0);
        tx_byte   = q.sbuf[7:0];
        busy      = (q.left != '0) || (q.rwait != 2'd0);
        if (tx_valid && tx_ready) begin
            d.sbuf    = {8'h00, q.sbuf[DATA_W-1:8]};
            d.left    = q.left - 1'b1;
            last_done = (q.left == CW'(1));
        end
        if (q.rwait == 2'd2) begin
            d.rwait = 2'd1;
        end else if (q.rwait == 2'd1) begin
            d.rwait = 2'd0;
            d.sbuf  = mem_rdata;
            d.left  = CW'(DBYTES);
        end
        if (load_ack) begin
            d.sbuf = DATA_W'(ACK_BYTE);
            d.left = CW'(1);
        end
        if (load_rd) d.rwait = 2'd2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a byte waits unchanged for the transmitter
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R11: the controller never loads a new response over an outstanding one
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ack || load_rd) |-> !busy);
endmodule

// File: rtl/hold_load_dbg.sv
module hold_load_dbg
    import hld_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          GAP_CYCLES = 65536,
    parameter logic [31:0] RESET_PC   = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_sel_dbg,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_hold,
    output logic              cpu_start,
    output logic [ADDR_W-1:0] cpu_start_addr
);
    logic              frm_ok;
    logic [7:0]        frm_cmd;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_data;
    logic              load_ack, load_rd, busy, last_done;

    hld_frame_rx #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frm_ok(frm_ok), .frm_cmd(frm_cmd), .frm_addr(frm_addr), .frm_data(frm_data)
    );

    hld_resp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_ack(load_ack), .load_rd(load_rd),
        .mem_rdata(mem_rdata), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .busy(busy), .last_done(last_done)
    );

    typedef struct packed {
        logic              run;
        logic              sel;
        logic              go_pend;
        logic              start;
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] maddr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.re     = 1'b0;
        d.start  = 1'b0;
        load_ack = 1'b0;
        load_rd  = 1'b0;
        if (last_done && q.go_pend) begin
            d.go_pend = 1'b0;
            d.run     = 1'b1;
            d.sel     = 1'b0;
            d.start   = 1'b1;
        end
        if (frm_ok && !busy) begin
            if (!q.run) begin
                d.sel = 1'b1;
                unique case (frm_cmd)
                    CMD_WRITE: begin
                        d.we     = 1'b1;
                        d.maddr  = frm_addr;
                        d.wdata  = frm_data;
                        load_ack = 1'b1;
                    end
                    CMD_SETPC: begin
                        d.pc     = frm_addr;
                        load_ack = 1'b1;
                    end
                    CMD_GO: begin
                        d.go_pend = 1'b1;
                        load_ack  = 1'b1;
                    end
                    CMD_READ: begin
                        d.re    = 1'b1;
                        d.maddr = frm_addr;
                        load_rd = 1'b1;
                    end
                    default: d.sel = q.sel;
                endcase
            end else if (frm_cmd == CMD_SETPC) begin
                d.pc = frm_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.pc    <= ADDR_W'(RESET_PC);
        end else begin
            q <= d;
        end
    end

    assign cpu_hold       = !q.run;
    assign cpu_start      = q.start;
    assign cpu_start_addr = q.pc;
    assign tx_sel_dbg     = q.sel;
    assign mem_we         = q.we;
    assign mem_re         = q.re;
    assign mem_addr       = q.maddr;
    assign mem_wdata      = q.wdata;

    // R8: single start pulse, and the CPU stays released
    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> (!cpu_start && !cpu_hold));
    assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hold |=> !cpu_hold);
    assert_start_gives_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> !tx_sel_dbg);
    // R10: memory is only touched while the CPU is held
    assert_mem_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> cpu_hold);
    // R3: responses only leave while the controller owns the transmitter
    assert_tx_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_sel_dbg);
    // R4: write strobe lasts one cycle
    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

// File: tb/tb_hold_load_dbg.sv
`timescale 1ns/1ps
module tb_hold_load_dbg;
    localparam int GAP = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_ready = 1'b1;
    logic        tx_valid, tx_sel_dbg, mem_we, mem_re, cpu_hold, cpu_start;
    logic [7:0]  tx_byte;
    logic [31:0] mem_addr, mem_wdata, cpu_start_addr;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    hold_load_dbg dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_sel_dbg(tx_sel_dbg), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_hold(cpu_hold), .cpu_start(cpu_start), .cpu_start_addr(cpu_start_addr)
    );

    // Program memory stand-in: 16 words, one-cycle read latency
    logic [31:0] mem [0:15];
    initial for (int i = 0; i < 16; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[5:2]];
    end

    int ncmp = 0, nerr = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic        e_run, e_sel, e_go, e_we, e_re, e_start;
    logic [31:0] e_pc, e_addr, e_wdata;
    logic [7:0]  e_txq [$];
    logic [7:0]  rq [$];
    int          e_rd, gap;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_run = 0; e_sel = 0; e_go = 0; e_we = 0; e_re = 0; e_start = 0;
            e_pc = 32'h8000_0000; e_addr = 0; e_wdata = 0;
            e_txq.delete(); rq.delete(); e_rd = 0; gap = 0;
        end else begin
            automatic bit busy = (e_txq.size() > 0) || (e_rd > 0);
            automatic bit ok = 0;
            automatic logic [7:0] c = 0, x = 0;
            automatic logic [31:0] fa = 0, fd = 0;
            e_we = 0; e_re = 0; e_start = 0;
            if (e_txq.size() > 0 && tx_ready) begin
                void'(e_txq.pop_front());
                if (e_txq.size() == 0 && e_go) begin
                    e_go = 0; e_run = 1; e_sel = 0; e_start = 1;
                end
            end
            if (e_rd == 2) e_rd = 1;
            else if (e_rd == 1) begin
                e_rd = 0;
                for (int i = 0; i < 4; i++) e_txq.push_back(mem_rdata[8*i +: 8]);
            end
            if (rx_valid) begin
                gap = 0;
                if (rq.size() == 0) begin
                    if (rx_byte == 8'hA5) rq.push_back(rx_byte);
                end else if (rq.size() == 1) begin
                    if (rx_byte >= 8'h01 && rx_byte <= 8'h04) rq.push_back(rx_byte);
                    else rq.delete();
                end else begin
                    rq.push_back(rx_byte);
                    if (rq.size() == 11) begin
                        foreach (rq[i]) x ^= rq[i];
                        ok = (x == 0);
                        c  = rq[1];
                        fa = {rq[5], rq[4], rq[3], rq[2]};
                        fd = {rq[9], rq[8], rq[7], rq[6]};
                        rq.delete();
                    end
                end
            end else if (rq.size() > 0) begin
                gap++;
                if (gap == GAP) begin rq.delete(); gap = 0; end
            end
            if (ok && !busy) begin
                if (!e_run) begin
                    e_sel = 1;
                    case (c)
                        8'h01: begin e_we = 1; e_addr = fa; e_wdata = fd; e_txq.push_back(8'h5A); end
                        8'h02: begin e_pc = fa; e_txq.push_back(8'h5A); end
                        8'h03: begin e_go = 1; e_txq.push_back(8'h5A); end
                        default: begin e_re = 1; e_addr = fa; e_rd = 2; end
                    endcase
                end else if (c == 8'h02) e_pc = fa;
            end
        end
    end

    // Per-clock comparison and event logging, sampled after the falling edge
    int we_cnt = 0, start_cnt = 0;
    logic [7:0] txlog [$];
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R8 cpu_hold", cpu_hold, !e_run);
            chk("R8 cpu_start", cpu_start, e_start);
            chk("R3 tx_sel_dbg", tx_sel_dbg, e_sel);
            chk("R5 cpu_start_addr", cpu_start_addr, e_pc);
            chk("R4 mem_we", mem_we, e_we);
            chk("R7 mem_re", mem_re, e_re);
            if (e_we || e_re) chk("R4 mem_addr", mem_addr, e_addr);
            if (e_we) chk("R4 mem_wdata", mem_wdata, e_wdata);
            chk("R6 tx_valid", tx_valid, e_txq.size() > 0);
            if (e_txq.size() > 0) chk("R6 tx_byte", tx_byte, e_txq[0]);
            if (mem_we) we_cnt++;
            if (cpu_start) start_cnt++;
            if (tx_valid && tx_ready) txlog.push_back(tx_byte);
        end
    end

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] cmd, input logic [31:0] a,
                              input logic [31:0] dw, input bit bad);
        logic [7:0] s;
        s = 8'hA5 ^ cmd;
        send_byte(8'hA5); send_byte(cmd);
        for (int i = 0; i < 4; i++) begin send_byte(a[8*i +: 8]); s ^= a[8*i +: 8]; end
        for (int i = 0; i < 4; i++) begin send_byte(dw[8*i +: 8]); s ^= dw[8*i +: 8]; end
        send_byte(bad ? (s ^ 8'h01) : s);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_log(input string tag, input logic [31:0] word, input int n);
        chk(tag, txlog.size(), n);
        for (int i = 0; i < n && i < txlog.size(); i++)
            chk(tag, txlog[i], (n == 1) ? 32'h5A : word[8*i +: 8]);
        txlog.delete();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000 && !done) begin
            nerr++; ncmp++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 cpu_hold", cpu_hold, 1);
        chk("R1 cpu_start", cpu_start, 0);
        chk("R1 tx_sel_dbg", tx_sel_dbg, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 cpu_start_addr", cpu_start_addr, 32'h8000_0000);

        // R9: noise, bad checksum, unknown command
        send_byte(8'h33); send_byte(8'h5A);
        send_frame(8'h01, 32'h0, 32'hCAFE_F00D, 1);
        idle(4);
        chk("R9 no write on bad sum", we_cnt, 0);
        chk("R9 mux untouched", tx_sel_dbg, 0);
        chk_log("R9 no response", 0, 0);
        send_byte(8'hA5); send_byte(8'h07);
        send_frame(8'h01, 32'h4, 32'h1122_3344, 0);
        idle(4);
        // R2 R3 R4 R6
        chk("R2 frame after resync", we_cnt, 1);
        chk("R3 mux to debug", tx_sel_dbg, 1);
        chk_log("R6 ack", 0, 1);
        send_frame(8'h01, 32'h8, 32'hDEAD_BEEF, 0);
        idle(4);
        chk_log("R6 ack second", 0, 1);

        // R7 with a stalled transmitter
        tx_ready = 1'b0;
        send_frame(8'h04, 32'h4, 32'h0, 0);
        idle(20);
        chk("R6 held byte", tx_byte, 8'h44);
        tx_ready = 1'b1;
        idle(8);
        chk_log("R7 read bytes", 32'h1122_3344, 4);

        // R11: frame during outstanding response is dropped
        tx_ready = 1'b0;
        send_frame(8'h04, 32'h8, 32'h0, 0);
        send_frame(8'h01, 32'h0, 32'h0000_0077, 0);
        idle(4);
        tx_ready = 1'b1;
        idle(8);
        chk("R11 write dropped", we_cnt, 2);
        chk_log("R11 read only", 32'hDEAD_BEEF, 4);

        // R5
        send_frame(8'h02, 32'h0000_0100, 32'h0, 0);
        idle(4);
        chk("R5 start address", cpu_start_addr, 32'h0000_0100);
        chk_log("R5 ack", 0, 1);

        // R12: abandoned partial frame
        send_byte(8'hA5); send_byte(8'h01); send_byte(8'h00);
        idle(GAP + 4);
        send_frame(8'h01, 32'hC, 32'h0000_0055, 0);
        idle(4);
        chk("R12 frame after timeout", we_cnt, 3);
        chk_log("R12 ack", 0, 1);

        // R8 start
        tx_ready = 1'b0;
        send_frame(8'h03, 32'h0, 32'h0, 0);
        idle(5);
        chk("R8 held before ack taken", cpu_hold, 1);
        tx_ready = 1'b1;
        idle(4);
        chk("R8 one pulse", start_cnt, 1);
        chk("R8 released", cpu_hold, 0);
        chk("R8 mux back to CPU", tx_sel_dbg, 0);
        chk_log("R8 ack", 0, 1);

        // R10: running
        send_frame(8'h01, 32'h0, 32'h1, 0);
        send_frame(8'h04, 32'h4, 32'h0, 0);
        send_frame(8'h03, 32'h0, 32'h0, 0);
        idle(6);
        chk("R10 no write", we_cnt, 3);
        chk("R10 no start", start_cnt, 1);
        chk("R10 mux stays CPU", tx_sel_dbg, 0);
        chk_log("R10 silent", 0, 0);
        send_frame(8'h02, 32'h0000_0200, 32'h0, 0);
        idle(3);
        chk("R10 address still set", cpu_start_addr, 32'h0000_0200);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end
endmodule